// File: doc/BRIEF.md
# Two-Stage Bus-Mapped Watchdog Timer

This block is a watchdog timer that software programs through a small register bus. A down-counter runs from a programmed reload value toward zero. The first time it reaches zero, the block raises an interrupt flag and starts the count again from the reload value. If that flag is still set the next time the counter reaches zero, and reset generation is enabled, the block asserts a system reset output. That output holds until the block itself is reset.

Software keeps the system alive in one of two ways: it writes the interrupt-clear register, which clears the flag and restarts the count, or it writes a new reload value. Before a second zero crossing, the worst-case time left is the current count plus the reload value plus one. A lock register protects every other register from stray writes, and only a 32-bit key value opens it. Reads are combinational on the address inputs and return zero for unmapped addresses. Writes take effect at the clock edge where `req_i` and `we_i` are both high.

Top module: `wdt_timer`

## Requirements
- R1: After reset, the reload register and the count both read 0xFFFFFFFF. Control, raw status, masked status and the lock indication read 0. `irq_o` and `sys_rst_o` are low.
- R2: A write to offset 0x000 stores the reload value and, at the same edge, loads the count with that value. Data 0 is stored and loaded as 1.
- R3: While control bit 0 (offset 0x008) is 1, the count at offset 0x004 drops by one each cycle. While that bit is 0, the count holds.
- R4: When the count is 0 at an edge while enabled and the raw flag is clear, the raw flag (bit 0 of offset 0x010) sets and the count reloads from the reload register.
- R5: When the count is 0 at an edge while enabled and the raw flag is already set, the count reloads. If control bit 1 is 1, `sys_rst_o` goes high. If control bit 1 is 0, `sys_rst_o` stays low and the flag stays set.
- R6: Once high, `sys_rst_o` stays high through any register write until `rst_ni` is asserted.
- R7: A write to offset 0x00C, with any data, clears the raw flag and reloads the count from the reload register.
- R8: The masked status (bit 0 of offset 0x014) and `irq_o` both equal the raw flag AND control bit 0.
- R9: Writing 0x1ACCE551 to offset 0xC00 unlocks the block. Writing any other value locks it. Offset 0xC00 reads 1 while locked and 0 while unlocked. While locked, writes to all other offsets are ignored.
- R10: Control reads back its two bits in bits 1:0 with the upper bits zero. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access valid |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 12 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Interrupt, equals masked status |
| sys_rst_o | output | 1 | Sticky system reset request |

## Verification
The bench builds the block with its default parameters: a 32-bit count, 12-bit offsets and the standard unlock key. Full-width values are covered through the reset state and through reload writes. Small reload values, from 1 to a few tens, bring both zero crossings within a few dozen cycles. This makes it practical to walk the interrupt, the masked view, the disabled-reset case and sticky reset generation cycle by cycle. A seeded random loop then checks the count against the expected value at random points inside a period, and tries random non-key lock values.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam logic [ADDR_W-1:0] OFS_LOAD  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_VALUE = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_LOCK  = 12'hC00;

  typedef struct packed {
    logic rst_en;
    logic cnt_en;
  } wdt_ctrl_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12,
  parameter logic [DATA_W-1:0] KEY = 32'h1ACCE551
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              raw_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] load_q_o,
  output logic [DATA_W-1:0] load_new_o,
  output wdt_pkg::wdt_ctrl_t ctrl_o,
  output logic              locked_o,
  output logic              load_wr_o,
  output logic              clr_wr_o
);
  import wdt_pkg::*;

  localparam logic [DATA_W-1:0] LOAD_MIN = DATA_W'(1);

  logic [DATA_W-1:0] load_q;
  wdt_ctrl_t         ctrl_q;
  logic              locked_q;
  logic              wr, open_wr;

  assign wr      = req_i & we_i;
  assign open_wr = wr & ~locked_q;

  assign load_new_o = (wdata_i == '0) ? LOAD_MIN : wdata_i;
  assign load_wr_o  = open_wr && (addr_i == OFS_LOAD);
  assign clr_wr_o   = open_wr && (addr_i == OFS_CLR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q   <= '1;
      ctrl_q   <= '0;
      locked_q <= 1'b0;
    end else begin
      if (load_wr_o) load_q <= load_new_o;
      if (open_wr && (addr_i == OFS_CTRL)) ctrl_q <= wdt_ctrl_t'(wdata_i[1:0]);
      if (wr && (addr_i == OFS_LOCK)) locked_q <= (wdata_i != KEY);
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_LOAD:  rdata_o = load_q;
      OFS_VALUE: rdata_o = cnt_i;
      OFS_CTRL:  rdata_o[1:0] = ctrl_q;
      OFS_RAW:   rdata_o[0] = raw_i;
      OFS_MASK:  rdata_o[0] = raw_i & ctrl_q.cnt_en;
      OFS_LOCK:  rdata_o[0] = locked_q;
      default:   rdata_o = '0;
    endcase
  end

  assign load_q_o = load_q;
  assign ctrl_o   = ctrl_q;
  assign locked_o = locked_q;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_en_i,
  input  logic              rst_en_i,
  input  logic              load_wr_i,
  input  logic              clr_wr_i,
  input  logic [DATA_W-1:0] load_q_i,
  input  logic [DATA_W-1:0] load_new_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              raw_o,
  output logic              sys_rst_o
);
  logic [DATA_W-1:0] cnt_q;
  logic              raw_q, rst_q;
  logic              at_zero;

  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
      raw_q <= 1'b0;
      rst_q <= 1'b0;
    end else if (load_wr_i) begin
      cnt_q <= load_new_i;
    end else if (clr_wr_i) begin
      cnt_q <= load_q_i;
      raw_q <= 1'b0;
    end else if (cnt_en_i) begin
      if (at_zero) begin
        cnt_q <= load_q_i;
        if (!raw_q) raw_q <= 1'b1;
        else if (rst_en_i) rst_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - DATA_W'(1);
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign raw_o     = raw_q;
  assign sys_rst_o = rst_q;
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12,
  parameter logic [DATA_W-1:0] KEY = 32'h1ACCE551
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              sys_rst_o
);
  import wdt_pkg::*;

  logic [DATA_W-1:0] load_q, load_new, cnt_q;
  wdt_ctrl_t         ctrl_q;
  logic              locked_q, load_wr, clr_wr, raw_q;

  wdt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .KEY(KEY)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .cnt_i      (cnt_q),
    .raw_i      (raw_q),
    .rdata_o    (rdata_o),
    .load_q_o   (load_q),
    .load_new_o (load_new),
    .ctrl_o     (ctrl_q),
    .locked_o   (locked_q),
    .load_wr_o  (load_wr),
    .clr_wr_o   (clr_wr)
  );

  wdt_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_en_i   (ctrl_q.cnt_en),
    .rst_en_i   (ctrl_q.rst_en),
    .load_wr_i  (load_wr),
    .clr_wr_i   (clr_wr),
    .load_q_i   (load_q),
    .load_new_i (load_new),
    .cnt_o      (cnt_q),
    .raw_o      (raw_q),
    .sys_rst_o  (sys_rst_o)
  );

  assign irq_o = raw_q & ctrl_q.cnt_en;
endmodule

// File: rtl/wdt_timer_chk.sv
module wdt_timer_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] load_q,
  input logic [DATA_W-1:0] cnt_q,
  input logic [1:0]        ctrl_bits,
  input logic              raw_q,
  input logic              locked_q,
  input logic              load_wr,
  input logic              clr_wr,
  input logic              irq_o,
  input logic              sys_rst_o
);
  p_load_nonzero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_q != '0);

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_bits[0] && !load_wr && !clr_wr) |=> cnt_q == $past(cnt_q));

  p_dec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_bits[0] && cnt_q != '0 && !load_wr && !clr_wr) |=> cnt_q == $past(cnt_q) - 1'b1);

  p_rst_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> ($past(raw_q) && $past(ctrl_bits[1])));

  p_rst_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |=> sys_rst_o);

  p_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> !raw_q);

  p_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (raw_q && ctrl_bits[0]));

  p_locked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_q && req_i && we_i && addr_i == wdt_pkg::OFS_LOAD) |=> $stable(load_q));
endmodule

bind wdt_timer wdt_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .load_q    (load_q),
  .cnt_q     (cnt_q),
  .ctrl_bits (ctrl_q),
  .raw_q     (raw_q),
  .locked_q  (locked_q),
  .load_wr   (load_wr),
  .clr_wr    (clr_wr),
  .irq_o     (irq_o),
  .sys_rst_o (sys_rst_o)
);

// File: tb/tb_wdt_timer.sv
module tb_wdt_timer;
  localparam logic [11:0] A_LOAD = 12'h000, A_VAL = 12'h004, A_CTRL = 12'h008,
                          A_CLR = 12'h00C, A_RAW = 12'h010, A_MASK = 12'h014,
                          A_LOCK = 12'hC00;
  localparam logic [31:0] KEY = 32'h1ACCE551;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, srst;

  int total = 0, bad = 0, cycles = 0;
  bit done = 1'b0;

  wdt_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .sys_rst_o(srst)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_count(input logic [31:0] v, input int n);
    return v - 32'(n);
  endfunction

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    rd(A_LOAD, d); chk("R1 load", d, 32'hFFFFFFFF);
    rd(A_VAL, d);  chk("R1 value", d, 32'hFFFFFFFF);
    rd(A_CTRL, d); chk("R1 ctrl", d, 0);
    rd(A_RAW, d);  chk("R1 raw", d, 0);
    rd(A_MASK, d); chk("R1 mask", d, 0);
    rd(A_LOCK, d); chk("R1 lock", d, 0);
    chk("R1 irq", irq, 0);
    chk("R1 sys_rst", srst, 0);

    // R2/R3 load while disabled, count holds
    wr(A_LOAD, 32'd10);
    rd(A_VAL, d); chk("R2 reload on write", d, 10);
    tick(5);
    rd(A_VAL, d); chk("R3 hold when disabled", d, 10);

    // R3 counting
    wr(A_CTRL, 32'd1);
    wr(A_LOAD, 32'd10);
    tick(4);
    rd(A_VAL, d); chk("R3 decrement", d, exp_count(10, 4));

    // R4 first expiry
    tick(6);
    rd(A_VAL, d); chk("R4 at zero", d, 0);
    rd(A_RAW, d); chk("R4 raw before expiry", d, 0);
    tick(1);
    rd(A_RAW, d); chk("R4 raw set", d, 1);
    rd(A_VAL, d); chk("R4 reloaded", d, 10);
    rd(A_MASK, d); chk("R8 mask set", d, 1);
    chk("R8 irq high", irq, 1);

    // R8 masking by control bit 0
    wr(A_CTRL, 32'd0);
    rd(A_MASK, d); chk("R8 mask cleared", d, 0);
    rd(A_RAW, d);  chk("R8 raw kept", d, 1);
    chk("R8 irq low", irq, 0);
    tick(3);
    rd(A_VAL, d); chk("R3 held after disable", d, 9);

    // R5 second expiry with reset disabled
    wr(A_CTRL, 32'd1);
    tick(9);
    rd(A_VAL, d); chk("R5 at zero again", d, 0);
    tick(1);
    chk("R5 no reset when bit1 clear", srst, 0);
    rd(A_VAL, d); chk("R5 reload on second expiry", d, 10);
    rd(A_RAW, d); chk("R5 raw stays set", d, 1);

    // R7 interrupt clear
    wr(A_CLR, 32'hDEADBEEF);
    rd(A_RAW, d); chk("R7 raw cleared", d, 0);
    rd(A_VAL, d); chk("R7 reload", d, 10);
    chk("R7 irq low", irq, 0);

    // R9 lock
    wr(A_LOCK, 32'h1);
    rd(A_LOCK, d); chk("R9 locked reads 1", d, 1);
    wr(A_LOAD, 32'd3);
    rd(A_LOAD, d); chk("R9 load write ignored", d, 10);
    wr(A_CTRL, 32'd0);
    rd(A_CTRL, d); chk("R9 ctrl write ignored", d, 1);
    wr(A_LOCK, KEY);
    rd(A_LOCK, d); chk("R9 unlocked reads 0", d, 0);

    // R2 zero clamps to one; R10 control bits and unmapped read
    wr(A_CTRL, 32'hFFFF_FFFC);
    rd(A_CTRL, d); chk("R10 ctrl upper bits", d, 0);
    wr(A_LOAD, 32'd0);
    rd(A_LOAD, d); chk("R2 zero stored as one", d, 1);
    rd(A_VAL, d);  chk("R2 zero loaded as one", d, 1);
    rd(12'h018, d); chk("R10 unmapped read", d, 0);

    // R3 random points inside a period; R9 random non-key lock values
    wr(A_CTRL, 32'd1);
    for (int i = 0; i < 25; i++) begin
      logic [31:0] v, k;
      int n;
      v = 32'($urandom_range(1, 40));
      n = $urandom_range(0, 32'(v));
      wr(A_CLR, 32'h0);
      wr(A_LOAD, v);
      tick(n);
      rd(A_VAL, d); chk("R3 random count", d, exp_count(v, n));
      rd(A_RAW, d); chk("R4 random no early flag", d, 0);
      k = $urandom();
      if (k == KEY) k = k ^ 32'h1;
      wr(A_LOCK, k);
      rd(A_LOCK, d); chk("R9 random lock value", d, 1);
      wr(A_LOCK, KEY);
    end

    // R5 reset generation
    wr(A_CTRL, 32'd3);
    wr(A_LOAD, 32'd5);
    tick(6);
    rd(A_RAW, d); chk("R5 first stage flag", d, 1);
    chk("R5 no reset at first stage", srst, 0);
    tick(5);
    chk("R5 reset not early", srst, 0);
    tick(1);
    chk("R5 reset asserted", srst, 1);

    // R6 sticky
    wr(A_CLR, 32'h0);
    wr(A_CTRL, 32'd0);
    tick(3);
    chk("R6 reset sticky", srst, 1);
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
    chk("R6 cleared by rst_ni", srst, 0);
    rd(A_VAL, d); chk("R1 value after reset", d, 32'hFFFFFFFF);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule